// File: doc/BRIEF.md
# Indexed Table Expander

The block keeps a private table of sixteen 32-bit entries in a 512-bit register of its own, apart from any vector datapath. A lookup request takes a 512-bit source vector full of small packed indices and picks a segment of sixteen consecutive indices. It then fetches the table entry named by each index and returns the sixteen entries as one 512-bit result. Slicing the indices and looking up the entries happen in one operation, so no unpacked vector of indices ever exists at the block's edge.

Indices are either 2 bits or 4 bits wide. With 2-bit indices a source vector carries 256 indices in sixteen segments, and only the first four table entries can be reached. With 4-bit indices it carries 128 indices in eight segments. Software loads the whole table in one write and then issues lookups. The result is registered and appears one cycle after the start pulse.

The control is a two-state machine. `ST_IDLE` is the resting state, and `ST_EMIT` means the output register holds a fresh result with `out_valid` high. The transitions are: `T_LAUNCH` (`ST_IDLE` to `ST_EMIT` on `start`), `T_CHAIN` (`ST_EMIT` to `ST_EMIT` on another `start`), `T_RETIRE` (`ST_EMIT` to `ST_IDLE` without `start`) and `T_WAIT` (`ST_IDLE` stays idle without `start`).

Top module: `idx_table_expander`

## Requirements
- R1: After reset `out_valid` is 0, `out_vec` is all zero, and every table entry is zero, so a lookup returns all zero.
- R2: When `tbl_wr_en` is high, all 512 table bits are replaced by `tbl_wr_data`, with entry k taken from bits [32k+31:32k]. No table bit changes while `tbl_wr_en` is low.
- R3: `out_valid` is high in exactly the cycles that follow a cycle with `start` high. Back-to-back starts keep it high.
- R4: When `idx_wide` is 1, index i sits at source bits [4i+3:4i]. Output lane j then holds table[index 16·s+j], where s = `seg_sel[2:0]`, and `seg_sel[3]` has no effect.
- R5: When `idx_wide` is 0, index i sits at source bits [2i+1:2i]. Output lane j then holds table[index 16·s+j], where s = `seg_sel[3:0]`, so only entries 0 to 3 appear.
- R6: A lookup issued in the same cycle as a table write uses the table contents from before that write. The next lookup uses the new contents.
- R7: In a cycle without `start`, `out_vec` keeps its previous value.
- R8: Output lane j occupies `out_vec` bits [32j+31:32j], with lane 0 in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Replace the whole table this cycle |
| tbl_wr_data | input | 512 | New table contents, entry k in bits [32k+31:32k] |
| start | input | 1 | Issue a lookup this cycle |
| src_vec | input | 512 | Packed index source |
| idx_wide | input | 1 | 1 selects 4-bit indices, 0 selects 2-bit indices |
| seg_sel | input | 4 | Segment of sixteen indices to consume |
| out_valid | output | 1 | Result in `out_vec` is new this cycle |
| out_vec | output | 512 | Sixteen looked-up 32-bit entries |

## Verification
Every cycle, the assertions check the timing relation between `start` and `out_valid`. They also check that the result holds still when no lookup is issued, that a write loads the exact word presented, and that the table stays fixed without a write. Other behaviour can only be shown by the bench's scenarios: the index slicing in both widths, segment choice including the ignored top select bit in wide mode, lane placement, and the old-table view when a write and a lookup share a cycle. The bench compares each result against a table model of its own.

// File: rtl/ite_pkg.sv
package ite_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ite_state_e;

    typedef enum logic {
        IDX_NARROW = 1'b0,
        IDX_WIDE   = 1'b1
    } ite_idx_mode_e;

    localparam int NARROW_IDX_W = 2;

endpackage

// File: rtl/ite_table.sv
module ite_table #(
    parameter int ENTRY_W   = 32,
    parameter int N_ENTRIES = 16,
    localparam int TBL_W    = ENTRY_W * N_ENTRIES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TBL_W-1:0] wr_data,
    output logic [TBL_W-1:0] tbl_flat
);

    logic [TBL_W-1:0] tbl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (wr_en) begin
            tbl_q <= wr_data;
        end
    end

    assign tbl_flat = tbl_q;

    // R2: a write loads the full word presented with it
    a_r2_write_replaces: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_q == $past(wr_data));

    // R2: no write, no change
    a_r2_table_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl_q));

endmodule

// File: rtl/ite_index_slicer.sv
module ite_index_slicer
    import ite_pkg::*;
#(
    parameter int ENTRY_W   = 32,
    parameter int N_ENTRIES = 16,
    localparam int LANES    = N_ENTRIES,
    localparam int VEC_W    = ENTRY_W * N_ENTRIES,
    localparam int WIDE_W   = $clog2(N_ENTRIES),
    localparam int SEG_W    = $clog2(VEC_W / (NARROW_IDX_W * LANES))
) (
    input  logic [VEC_W-1:0]        src,
    input  ite_idx_mode_e           mode,
    input  logic [SEG_W-1:0]        seg,
    output logic [LANES*WIDE_W-1:0] idx_flat
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [NARROW_IDX_W-1:0] idx_n;
        logic [WIDE_W-1:0]       idx_w;

        assign idx_n = src[(int'(seg) * LANES + j) * NARROW_IDX_W +: NARROW_IDX_W];
        assign idx_w = src[(int'(seg[SEG_W-2:0]) * LANES + j) * WIDE_W +: WIDE_W];

        always_comb begin
            unique case (mode)
                IDX_WIDE:   idx_flat[j*WIDE_W +: WIDE_W] = idx_w;
                IDX_NARROW: idx_flat[j*WIDE_W +: WIDE_W] = WIDE_W'(idx_n);
                default:    idx_flat[j*WIDE_W +: WIDE_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/ite_lane_lookup.sv
module ite_lane_lookup #(
    parameter int ENTRY_W   = 32,
    parameter int N_ENTRIES = 16,
    localparam int LANES    = N_ENTRIES,
    localparam int TBL_W    = ENTRY_W * N_ENTRIES,
    localparam int WIDE_W   = $clog2(N_ENTRIES)
) (
    input  logic [TBL_W-1:0]        tbl_flat,
    input  logic [LANES*WIDE_W-1:0] idx_flat,
    output logic [TBL_W-1:0]        lanes_flat
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [WIDE_W-1:0] sel;
        assign sel = idx_flat[j*WIDE_W +: WIDE_W];
        assign lanes_flat[j*ENTRY_W +: ENTRY_W] = tbl_flat[int'(sel) * ENTRY_W +: ENTRY_W];
    end

endmodule

// File: rtl/idx_table_expander.sv
module idx_table_expander
    import ite_pkg::*;
#(
    parameter int ENTRY_W   = 32,
    parameter int N_ENTRIES = 16,
    localparam int LANES    = N_ENTRIES,
    localparam int VEC_W    = ENTRY_W * N_ENTRIES,
    localparam int WIDE_W   = $clog2(N_ENTRIES),
    localparam int SEG_W    = $clog2(VEC_W / (NARROW_IDX_W * LANES))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr_en,
    input  logic [VEC_W-1:0] tbl_wr_data,
    input  logic             start,
    input  logic [VEC_W-1:0] src_vec,
    input  logic             idx_wide,
    input  logic [SEG_W-1:0] seg_sel,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec
);

    ite_state_e             state_q, state_d;
    ite_idx_mode_e          mode;
    logic [VEC_W-1:0]       tbl_flat;
    logic [LANES*WIDE_W-1:0] idx_flat;
    logic [VEC_W-1:0]       lanes_flat;
    logic [VEC_W-1:0]       out_q;

    assign mode = idx_wide ? IDX_WIDE : IDX_NARROW;

    ite_table #(
        .ENTRY_W   (ENTRY_W),
        .N_ENTRIES (N_ENTRIES)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_data  (tbl_wr_data),
        .tbl_flat (tbl_flat)
    );

    ite_index_slicer #(
        .ENTRY_W   (ENTRY_W),
        .N_ENTRIES (N_ENTRIES)
    ) u_slicer (
        .src      (src_vec),
        .mode     (mode),
        .seg      (seg_sel),
        .idx_flat (idx_flat)
    );

    ite_lane_lookup #(
        .ENTRY_W   (ENTRY_W),
        .N_ENTRIES (N_ENTRIES)
    ) u_lookup (
        .tbl_flat   (tbl_flat),
        .idx_flat   (idx_flat),
        .lanes_flat (lanes_flat)
    );

    // next-state logic: T_LAUNCH, T_CHAIN, T_RETIRE, T_WAIT
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = start ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result register: captured against the table as it stands before this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (start) begin
            out_q <= lanes_flat;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_EMIT: out_valid = 1'b1;
            ST_IDLE: out_valid = 1'b0;
            default: out_valid = 1'b0;
        endcase
        out_vec = out_q;
    end

    // R3: a start yields valid on the next cycle
    a_r3_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> out_valid);

    // R3: no start, no valid next cycle
    a_r3_valid_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !out_valid);

    // R7: result holds between lookups
    a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(out_vec));

endmodule

// File: tb/idx_table_expander_bench.sv
module idx_table_expander_bench;

    localparam int EW    = 32;
    localparam int NE    = 16;
    localparam int VW    = EW * NE;

    typedef struct {
        logic [VW-1:0] exp;
        string         tag;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_wr_en = 1'b0;
    logic [VW-1:0] tbl_wr_data = '0;
    logic          start = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic          idx_wide = 1'b0;
    logic [3:0]    seg_sel = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int            n_checks = 0;
    int            n_fails = 0;
    int            cycles = 0;
    bit            done = 1'b0;
    logic [VW-1:0] model_tbl = '0;
    sb_item_t      sb_q[$];

    always #2 clk = ~clk;

    idx_table_expander u_idx_table_expander (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_data (tbl_wr_data),
        .start       (start),
        .src_vec     (src_vec),
        .idx_wide    (idx_wide),
        .seg_sel     (seg_sel),
        .out_valid   (out_valid),
        .out_vec     (out_vec)
    );

    function automatic logic [VW-1:0] expect_out(input logic [VW-1:0] tbl,
            input logic [VW-1:0] src, input logic wide, input logic [3:0] seg);
        logic [VW-1:0] r = '0;
        for (int j = 0; j < 16; j++) begin
            int idx;
            if (wide) idx = int'(src[((int'(seg[2:0]) * 16) + j) * 4 +: 4]);
            else      idx = int'(src[((int'(seg) * 16) + j) * 2 +: 2]);
            r[j*32 +: 32] = tbl[idx*32 +: 32];
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] pattern(input int seed);
        logic [VW-1:0] r;
        for (int k = 0; k < 16; k++)
            r[k*32 +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(k) * 32'h85EBCA6B) ^ 32'h5A5A0F0F;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_tbl(input logic [VW-1:0] d);
        @(negedge clk);
        tbl_wr_en   = 1'b1;
        tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en   = 1'b0;
        model_tbl   = d;
    endtask

    // driver: issues a lookup and pushes the expected result
    task automatic issue(input logic wide, input logic [3:0] seg, input logic [VW-1:0] src,
                         input string tag, input logic do_wr = 1'b0,
                         input logic [VW-1:0] wd = '0);
        sb_item_t it;
        start     = 1'b1;
        idx_wide  = wide;
        seg_sel   = seg;
        src_vec   = src;
        tbl_wr_en = do_wr;
        tbl_wr_data = wd;
        it.exp = expect_out(model_tbl, src, wide, seg);
        it.tag = tag;
        sb_q.push_back(it);
        if (do_wr) model_tbl = wd;
        @(negedge clk);
        start     = 1'b0;
        tbl_wr_en = 1'b0;
    endtask

    // monitor: pops and compares each valid result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3 unexpected valid", VW'(out_valid), '0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(out_vec === it.exp, it.tag, out_vec, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] t1, t2, src_id, held;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(out_valid === 1'b0, "R1 valid after reset", VW'(out_valid), '0);
        check(out_vec === '0, "R1 out_vec after reset", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b1, 4'd0, pattern(3), "R1 lookup of zero table");
        @(negedge clk);

        // R2 / R8: identity indices return the table in lane order
        t1 = pattern(11);
        write_tbl(t1);
        src_id = '0;
        for (int i = 0; i < 16; i++) src_id[i*4 +: 4] = 4'(i);
        issue(1'b1, 4'd0, src_id, "R2 R8 identity readback");
        // R8: reversed indices reverse the lanes
        src_id = '0;
        for (int i = 0; i < 16; i++) src_id[i*4 +: 4] = 4'(15 - i);
        issue(1'b1, 4'd0, src_id, "R8 reversed lanes");
        @(negedge clk);
        check(out_valid === 1'b0, "R3 valid low after last start", VW'(out_valid), '0);

        // R4: wide mode, several segments, top select bit ignored
        issue(1'b1, 4'd3, pattern(21), "R4 wide seg 3");
        issue(1'b1, 4'd7, pattern(22), "R4 wide seg 7");
        issue(1'b1, 4'd15, pattern(22), "R4 wide seg 15 equals seg 7");
        issue(1'b1, 4'd8, pattern(23), "R4 wide seg 8 equals seg 0");

        // R5: narrow mode, entries 0..3 only
        issue(1'b0, 4'd0, pattern(31), "R5 narrow seg 0");
        issue(1'b0, 4'd5, pattern(32), "R5 narrow seg 5");
        issue(1'b0, 4'd15, {VW{1'b1}}, "R5 narrow seg 15 all ones");
        @(negedge clk);

        // R7: result holds while idle
        held = out_vec;
        repeat (3) @(negedge clk);
        check(out_vec === held, "R7 hold while idle", out_vec, held);
        check(out_valid === 1'b0, "R3 valid low while idle", VW'(out_valid), '0);

        // R6: lookup with simultaneous write sees old table; next sees new
        t2 = pattern(77);
        issue(1'b1, 4'd1, pattern(41), "R6 same-cycle write uses old table", 1'b1, t2);
        issue(1'b1, 4'd1, pattern(41), "R6 next lookup uses new table");
        @(negedge clk);

        // R3: isolated start after gap
        issue(1'b0, 4'd9, pattern(51), "R3 isolated start");
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R3 scoreboard drained", VW'(sb_q.size()), '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule